// File: doc/BRIEF.md
# Double-Buffered Edge-Safe PWM Timer

This block is a free-running up-counter that wraps at a programmable limit. It drives one PWM output from two 16-bit compare channels that act as alternating buffers. Software loads a new pulse width into either channel over a byte-wide register bus, writing the upper byte first and the lower byte second. The channel whose lower byte was written most recently is armed. At the next counter wrap it becomes the active compare value.

The output is high from the start of each period until the counter reaches the active compare value. The active value is captured only at a wrap. A write that lands on a wrap cycle or a compare cycle therefore cannot shorten or stretch the period in progress, so the output never shows a stray 0% or 100% pulse. Two sticky flags report wrap events and compare events. Software clears them by writing ones.

Top module: `pwm_dualbuf`

## Requirements
- R1: After reset the count is 0, both channels hold 0, the active compare value is 0, and `pwm_out`, `ovf_flag` and `cmp_flag` are all 0.
- R2: The count runs from 0 to `wrap_val` and then returns to 0, giving a period of `wrap_val`+1 cycles. The cycle in which the count equals `wrap_val` is the wrap event.
- R3: With an active compare value C where 1 <= C <= `wrap_val`, `pwm_out` is high exactly while the count is below C, which is C cycles per period.
- R4: An active compare value of 0 keeps `pwm_out` low for the whole period. A value above `wrap_val` keeps it high for the whole period, with no low cycle at the wrap.
- R5: A committed channel write takes effect from the first period that starts after the commit. The active compare value changes only when the count returns to 0.
- R6: Writing a channel's upper byte only stores it in that channel's holding byte. The 16-bit channel value commits when the lower byte is written, as {holding byte, low byte}. An upper-byte write to the armed channel disarms it until its lower byte is written again.
- R7: A lower-byte write in the same cycle as a wrap event does not affect the period that begins at that wrap. It is applied at the following wrap.
- R8: `ovf_flag` sets on each wrap event and `cmp_flag` sets in every cycle where the count equals the active compare value. Each flag stays set until a clear write with a 1 in its bit (bit 0 for `ovf_flag`, bit 1 for `cmp_flag`). A set in the same cycle as a clear wins.
- R9: Bus map for a write (`bus_we`=1), by `bus_addr`: 0 = channel 0 upper byte, 1 = channel 0 lower byte, 2 = channel 1 upper byte, 3 = channel 1 lower byte, 4 = flag clear. Writes to addresses 5 to 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrap_val | input | 16 | Last count value of a period |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| pwm_out | output | 1 | Registered PWM output |
| ovf_flag | output | 1 | Sticky wrap-event flag |
| cmp_flag | output | 1 | Sticky compare-event flag |

## Verification
The assertions take `wrap_val` to be nonzero and held constant whenever reset is released. The bench changes it only while reset is asserted. The bus protocol itself is left unconstrained: the random stimulus issues lone upper-byte writes, repeated lower-byte writes, writes to unmapped addresses and clear writes in any cycle, including wrap and compare cycles. Directed cases place a lower-byte commit exactly on a wrap cycle and cancel an armed channel with a fresh upper-byte write.

// File: rtl/pwm_dualbuf.sv
module pwm_dualbuf #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*DW-1:0]    wrap_val,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic               pwm_out,
  output logic               ovf_flag,
  output logic               cmp_flag
);
  localparam int CW = 2 * DW;
  localparam logic [AW-1:0] CLR_ADDR = AW'(4);

  logic [CW-1:0] cnt, cmp_act;
  logic [CW-1:0] chv  [2];
  logic [DW-1:0] hold [2];
  logic          pend, pend_ch, pwm_q, ovf_q, cmpf_q;

  wire ch_wr  = bus_we && !bus_addr[2] && (bus_addr[AW-1:0] < AW'(4));
  wire sel    = bus_addr[1];
  wire hi_wr  = ch_wr && !bus_addr[0];
  wire lo_wr  = ch_wr &&  bus_addr[0];
  wire clr_wr = bus_we && (bus_addr == CLR_ADDR);

  wire wrap_hit = (cnt >= wrap_val);
  wire oc_hit   = (cnt == cmp_act);
  wire swap     = wrap_hit && pend;

  wire [CW-1:0] cnt_n = wrap_hit ? '0 : cnt + 1'b1;
  wire [CW-1:0] cmp_n = swap ? chv[pend_ch] : cmp_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      cmp_act <= '0;
      pwm_q   <= 1'b0;
      pend    <= 1'b0;
      pend_ch <= 1'b0;
      ovf_q   <= 1'b0;
      cmpf_q  <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        chv[i]  <= '0;
        hold[i] <= '0;
      end
    end else begin
      cnt     <= cnt_n;
      cmp_act <= cmp_n;
      pwm_q   <= (cnt_n < cmp_n);
      if (hi_wr) hold[sel] <= bus_wdata;
      if (lo_wr) chv[sel]  <= {hold[sel], bus_wdata};
      if (lo_wr) begin
        pend    <= 1'b1;
        pend_ch <= sel;
      end else if (hi_wr && pend && (pend_ch == sel)) begin
        pend    <= 1'b0;
      end else if (wrap_hit) begin
        pend    <= 1'b0;
      end
      ovf_q  <= wrap_hit | (ovf_q  & ~(clr_wr & bus_wdata[0]));
      cmpf_q <= oc_hit   | (cmpf_q & ~(clr_wr & bus_wdata[1]));
    end
  end

  assign pwm_out  = pwm_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmpf_q;
endmodule

// File: rtl/pwm_dualbuf_chk.sv
module pwm_dualbuf_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] wrap_val,
  input logic          bus_we,
  input logic [2:0]    bus_addr,
  input logic          clr0,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp_act,
  input logic          pend,
  input logic          pend_ch,
  input logic          pwm_out,
  input logic          ovf_flag
);
  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= wrap_val);

  // R3
  pwm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_out == (cnt < cmp_act));

  // R5
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_act) |-> cnt == '0);

  // R6
  hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[2:1] != 2'b10 && !bus_addr[2] && !bus_addr[0] &&
     pend && pend_ch == bus_addr[1] && cnt < wrap_val) |=> !pend);

  // R7
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr[2] && bus_addr[0] && cnt >= wrap_val) |=> (pend && cnt == '0));

  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= wrap_val) |=> ovf_flag);

  // R8
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !(bus_we && bus_addr == 3'd4 && clr0)) |=> ovf_flag);
endmodule

bind pwm_dualbuf pwm_dualbuf_chk #(.CW(2*DW)) chk (
  .clk(clk), .rst_n(rst_n), .wrap_val(wrap_val), .bus_we(bus_we),
  .bus_addr(bus_addr), .clr0(bus_wdata[0]), .cnt(cnt), .cmp_act(cmp_act),
  .pend(pend), .pend_ch(pend_ch), .pwm_out(pwm_out), .ovf_flag(ovf_flag)
);

// File: tb/pwm_dualbuf_test.sv
`timescale 1ns/1ps
module pwm_dualbuf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wrap_val = 16'd9;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        pwm_out, ovf_flag, cmp_flag;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  pwm_dualbuf uut (.clk(clk), .rst_n(rst_n), .wrap_val(wrap_val), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pwm_out(pwm_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  always #2.5 clk = ~clk;

  // reference state
  logic [15:0] m_cnt, m_cmp;
  logic [15:0] m_ch [2];
  logic [7:0]  m_hold [2];
  logic        m_pend, m_pch, m_pwm, m_ovf, m_ocf;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cnt = 0; m_cmp = 0; m_ch[0] = 0; m_ch[1] = 0; m_hold[0] = 0; m_hold[1] = 0;
    m_pend = 0; m_pch = 0; m_pwm = 0; m_ovf = 0; m_ocf = 0;
  endtask

  task automatic m_step(input bit we, input logic [2:0] a, input logic [7:0] d);
    bit wh, oc, chw, hi, lo, s, clr;
    logic [15:0] ncnt, ncmp;
    wh = (m_cnt >= wrap_val);
    oc = (m_cnt == m_cmp);
    ncnt = wh ? 16'd0 : m_cnt + 16'd1;
    ncmp = (wh && m_pend) ? m_ch[m_pch] : m_cmp;
    chw = we && (a < 3'd4);
    s = a[1];
    hi = chw && !a[0];
    lo = chw && a[0];
    clr = we && (a == 3'd4);
    if (lo) begin
      m_ch[s] = {m_hold[s], d};
      m_pend = 1; m_pch = s;
    end else if (hi && m_pend && m_pch == s) m_pend = 0;
    else if (wh) m_pend = 0;
    if (hi) m_hold[s] = d;
    m_ovf = wh | (m_ovf & ~(clr & d[0]));
    m_ocf = oc | (m_ocf & ~(clr & d[1]));
    m_cnt = ncnt; m_cmp = ncmp;
    m_pwm = (ncnt < ncmp);
  endtask

  task automatic compare_all();
    string t;
    t = (m_cmp == 0 || m_cmp > wrap_val) ? "R4" : "R3";
    check(pwm_out == m_pwm, t, pwm_out, m_pwm);
    check(ovf_flag == m_ovf, "R2", ovf_flag, m_ovf);
    check(cmp_flag == m_ocf, "R8", cmp_flag, m_ocf);
  endtask

  task automatic cyc(input bit we, input logic [2:0] a, input logic [7:0] d);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    m_step(we, a, d);
    @(negedge clk);
    bus_we = 0;
    compare_all();
  endtask

  task automatic idle(); cyc(0, 3'd0, 8'd0); endtask

  task automatic wr16(input bit ch, input logic [15:0] v);
    cyc(1, {1'b0, ch, 1'b0}, v[15:8]);
    cyc(1, {1'b0, ch, 1'b1}, v[7:0]);
  endtask

  task automatic do_reset(input logic [15:0] w);
    @(negedge clk);
    rst_n = 0; bus_we = 0; wrap_val = w;
    repeat (3) @(negedge clk);
    m_reset();
    rst_n = 1;
    // R1
    check(pwm_out == 0, "R1", pwm_out, 0);
    check(ovf_flag == 0, "R1", ovf_flag, 0);
    check(cmp_flag == 0, "R1", cmp_flag, 0);
  endtask

  task automatic period_high(output int n);
    while (m_cnt != 0) idle();
    n = 0;
    for (int i = 0; i <= int'(wrap_val); i++) begin
      n += pwm_out;
      idle();
    end
  endtask

  initial begin
    int h;
    do_reset(16'd9);
    repeat (3) idle();
    // R9, R5: channel 1 = 4, applies only after a wrap
    wr16(1, 16'd4);
    check(pwm_out == 0, "R5", pwm_out, 0);
    period_high(h); check(h == 4, "R5", h, 4);
    // R6: arm channel 0 with 6, cancel by a lone upper write
    wr16(0, 16'd6);
    cyc(1, 3'd0, 8'd0);
    period_high(h); period_high(h); check(h == 4, "R6", h, 4);
    cyc(1, 3'd1, 8'd2);
    period_high(h); period_high(h); check(h == 2, "R6", h, 2);
    // R4: zero and above-wrap values
    wr16(1, 16'd0);
    period_high(h); period_high(h); check(h == 0, "R4", h, 0);
    wr16(1, 16'h0100);
    period_high(h); period_high(h); check(h == 10, "R4", h, 10);
    // R7: lower-byte commit on the wrap cycle
    while (m_cnt != wrap_val - 1) idle();
    cyc(1, 3'd0, 8'd0);
    cyc(1, 3'd1, 8'd7);
    period_high(h); check(h == 10, "R7", h, 10);
    period_high(h); check(h == 7, "R7", h, 7);
    // R8: clear overflow only
    while (m_cnt != 2) idle();
    cyc(1, 3'd4, 8'd1);
    check(ovf_flag == 0, "R8", ovf_flag, 0);
    // R9: unmapped address write has no effect
    cyc(1, 3'd5, 8'hFF);
    check(ovf_flag == 0, "R9", ovf_flag, 0);
    period_high(h); check(h == 7, "R9", h, 7);
    // random rounds
    void'($urandom(32'h5eed1234));
    for (int r = 0; r < 3; r++) begin
      do_reset(16'($urandom_range(3, 40)));
      for (int k = 0; k < 2500; k++) begin
        if ($urandom_range(0, 3) == 0) begin
          logic [2:0] a;
          logic [7:0] d;
          a = 3'($urandom_range(0, 7));
          d = 8'($urandom_range(0, 255));
          if (!a[0] && a < 3'd4 && $urandom_range(0, 3) != 0) d = 8'd0;
          else if (a[0] && a < 3'd4) d = 8'($urandom_range(0, 48));
          cyc(1, a, d);
        end else idle();
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule